// File: doc/BRIEF.md
# Single-Wire Bus Master Controller

This block is a register-mapped master for an open-drain single-wire bus with several independent bus ports. Software writes one control/status word that chooses a port and a speed, and starts one bus operation. The operation is either a reset pulse followed by a presence check, or a single bit time slot. The block pulls the selected line low for the right number of microsecond ticks. It samples the line at a fixed point in the operation and writes the sampled level back into the same word. The same word reports when the operation has finished.

A second register holds two clock prescalers, one for normal speed and one for overdrive speed. A tick lasts prescaler+1 clock cycles, and every duration of the bus protocol is counted in ticks. A read slot is a write slot that transmits a 1: if a device pulls the line low, the bit read back is 0. After a reset operation, a data bit of 0 means at least one device answered. An interrupt flag is set when each operation ends. It drives the interrupt output when the enable bit is set. The strong-pullup power bits are only stored and read back.

Top module: `swm_top`

## Requirements
- R1: After reset the control/status word (offset 0x0) reads 0, the interrupt output is 0, no line is pulled low, and the divider word (offset 0x4) reads 0x003E00AF (normal prescaler 175 in bits 15:0, overdrive prescaler 62 in bits 31:16).
- R2: The divider word can be written and read back. The normal prescaler is in bits 15:0 and the overdrive prescaler is in bits 31:16.
- R3: Writing the control/status word with bit 3 (cycle) set starts one operation. Bit 3 reads 1 while the operation runs and reads 0 once it has finished.
- R4: With bit 1 (reset request) set, the selected line is pulled low for 480 ticks at normal speed. The line is sampled 70 ticks after release, and the whole operation takes 960 ticks. Afterwards bit 0 reads 0 if a device pulled the line low at that sample point, and 1 otherwise.
- R5: With bit 1 clear, one slot transmits bit 0 of the written word. At normal speed a 0 pulls the line low for 60 ticks, a 1 pulls it low for 6 ticks, and the slot lasts 64 ticks.
- R6: A slot samples the line at tick 15 (normal speed). Afterwards bit 0 holds the sampled level, so a read slot (data 1) returns 0 when a device holds the line low.
- R7: With bit 2 (overdrive) set, ticks come from the overdrive prescaler. Reset is low for 48 ticks, is sampled 7 ticks after release, and ends at tick 96. A slot pulls low for 6 ticks (data 0) or 1 tick (data 1), samples at tick 2, and ends at tick 8.
- R8: Bits 11:8 select the port. Only the selected port's line is pulled low. A port number of 4 or more (with the default 4 ports) pulls no line and samples 1.
- R9: A write to the control/status word while bit 3 reads 1 has no effect on any stored field or on the running operation.
- R10: At the end of every operation, bit 6 (interrupt flag) is set. The interrupt output equals bit 6 AND bit 7 (interrupt enable). The next accepted write to the control/status word clears bit 6.
- R11: A tick lasts prescaler+1 clock cycles. The prescaler is captured when the operation starts, so changing the divider word during an operation does not change that operation's timing.
- R12: Bit 4 and bits 31:16 of the control/status word are stored and read back. They have no effect on the lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 4 | Byte address of the register access |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| busPullLow | output | NUM_PORTS | Per-port open-drain drive: 1 pulls the line low |
| busSense | input | NUM_PORTS | Per-port sampled line level |
| irqOut | output | 1 | Interrupt request |

## Verification
The bench counts the exact number of cycles each line is held low. This catches a design that swaps the data-0 and data-1 pulse lengths, mixes up the two prescalers, or uses a tick of prescaler cycles instead of prescaler+1. A modelled device answers only inside a window around the expected sample point. A design that samples at the wrong tick, or that reports presence with the wrong polarity, therefore returns the wrong data bit. Other tests check port isolation, including an out-of-range port that must drive nothing. They also check writes issued while an operation is busy, which must change nothing, and a divider change in mid-operation, which must not shorten the pulse.

// File: rtl/swm_pkg.sv
package swm_pkg;
  localparam int TICK_W = 10;

  // Normal-speed durations in ticks
  localparam int NRM_RST_LOW  = 480;
  localparam int NRM_RST_SAMP = 550;
  localparam int NRM_RST_END  = 960;
  localparam int NRM_LOW0     = 60;
  localparam int NRM_LOW1     = 6;
  localparam int NRM_SAMP     = 15;
  localparam int NRM_END      = 64;
  // Overdrive durations in ticks
  localparam int OVD_RST_LOW  = 48;
  localparam int OVD_RST_SAMP = 55;
  localparam int OVD_RST_END  = 96;
  localparam int OVD_LOW0     = 6;
  localparam int OVD_LOW1     = 1;
  localparam int OVD_SAMP     = 2;
  localparam int OVD_END      = 8;

  typedef struct packed {
    logic        start;
    logic        rstOp;
    logic        ovd;
    logic        txBit;
    logic [3:0]  port;
    logic [15:0] div;
  } swmCmd_t;
endpackage

// File: rtl/swm_timing.sv
module swm_timing
  import swm_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  swmCmd_t              cmd,
  input  logic [NUM_PORTS-1:0] busSense,
  output logic [NUM_PORTS-1:0] busPullLow,
  output logic                 opDone,
  output logic                 rxBit
);
  logic              busy;
  logic [15:0]       preCnt, divQ;
  logic [TICK_W-1:0] tickCnt, lowLen, sampAt, endAt;
  logic              rstQ, ovdQ, bitQ, rxQ;
  logic [3:0]        portQ;
  logic [NUM_PORTS-1:0] selMask;
  logic              tick, pullActive, senseSel;

  always_comb begin
    if (rstQ) begin
      lowLen = ovdQ ? TICK_W'(OVD_RST_LOW)  : TICK_W'(NRM_RST_LOW);
      sampAt = ovdQ ? TICK_W'(OVD_RST_SAMP) : TICK_W'(NRM_RST_SAMP);
      endAt  = ovdQ ? TICK_W'(OVD_RST_END)  : TICK_W'(NRM_RST_END);
    end else begin
      if (ovdQ) lowLen = bitQ ? TICK_W'(OVD_LOW1) : TICK_W'(OVD_LOW0);
      else      lowLen = bitQ ? TICK_W'(NRM_LOW1) : TICK_W'(NRM_LOW0);
      sampAt = ovdQ ? TICK_W'(OVD_SAMP) : TICK_W'(NRM_SAMP);
      endAt  = ovdQ ? TICK_W'(OVD_END)  : TICK_W'(NRM_END);
    end
  end

  assign tick       = busy && (preCnt == divQ);
  assign pullActive = busy && (tickCnt < lowLen);
  assign opDone     = tick && (tickCnt == endAt - TICK_W'(1));
  assign senseSel   = ~|(~busSense & selMask);
  assign rxBit      = rxQ;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    assign selMask[i]    = (portQ == 4'(i));
    assign busPullLow[i] = pullActive && selMask[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0; preCnt <= '0; divQ <= '0; tickCnt <= '0;
      rstQ <= 1'b0; ovdQ <= 1'b0; bitQ <= 1'b1; portQ <= '0; rxQ <= 1'b1;
    end else if (cmd.start) begin
      busy <= 1'b1; preCnt <= '0; tickCnt <= '0; divQ <= cmd.div;
      rstQ <= cmd.rstOp; ovdQ <= cmd.ovd; bitQ <= cmd.txBit; portQ <= cmd.port;
    end else if (busy) begin
      if (tick) begin
        preCnt  <= '0;
        tickCnt <= tickCnt + TICK_W'(1);
        if (tickCnt == sampAt - TICK_W'(1)) rxQ <= senseSel;
        if (opDone) busy <= 1'b0;
      end else begin
        preCnt <= preCnt + 16'd1;
      end
    end
  end

  p_one_line_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(busPullLow));
  p_pull_needs_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    (|busPullLow) |-> busy);
  p_tick_bound_r11: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (tickCnt < endAt));
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !cmd.start);
endmodule

// File: rtl/swm_ctrl.sv
module swm_ctrl
  import swm_pkg::*;
#(
  parameter int          ADDR_W      = 4,
  parameter logic [15:0] DIV_NRM_RST = 16'd175,
  parameter logic [15:0] DIV_OVD_RST = 16'd62
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              opDone,
  input  logic              rxBit,
  output swmCmd_t           cmd,
  output logic              irqOut
);
  logic        dataQ, rstQ, ovdQ, cycQ, pwrQ, flagQ, ienQ;
  logic [3:0]  selQ;
  logic [15:0] pwrFieldQ, divNrm, divOvd;
  logic        csrSel, cdrSel, acceptCsr;
  logic [31:0] csrWord;

  assign csrSel    = (regAddr == ADDR_W'(0));
  assign cdrSel    = (regAddr == ADDR_W'(4));
  assign acceptCsr = regWrEn && csrSel && !cycQ;

  assign cmd.start = acceptCsr && regWrData[3];
  assign cmd.rstOp = regWrData[1];
  assign cmd.ovd   = regWrData[2];
  assign cmd.txBit = regWrData[0];
  assign cmd.port  = regWrData[11:8];
  assign cmd.div   = regWrData[2] ? divOvd : divNrm;

  assign csrWord = {pwrFieldQ, 4'b0, selQ, ienQ, flagQ, 1'b0, pwrQ,
                    cycQ, ovdQ, rstQ, dataQ};
  assign regRdData = csrSel ? csrWord : (cdrSel ? {divOvd, divNrm} : 32'd0);
  assign irqOut = flagQ && ienQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ <= 1'b0; rstQ <= 1'b0; ovdQ <= 1'b0; cycQ <= 1'b0; pwrQ <= 1'b0;
      flagQ <= 1'b0; ienQ <= 1'b0; selQ <= '0; pwrFieldQ <= '0;
      divNrm <= DIV_NRM_RST; divOvd <= DIV_OVD_RST;
    end else begin
      if (acceptCsr) begin
        dataQ     <= regWrData[0];
        rstQ      <= regWrData[1];
        ovdQ      <= regWrData[2];
        cycQ      <= regWrData[3];
        pwrQ      <= regWrData[4];
        ienQ      <= regWrData[7];
        selQ      <= regWrData[11:8];
        pwrFieldQ <= regWrData[31:16];
        flagQ     <= 1'b0;
      end else if (opDone) begin
        cycQ  <= 1'b0;
        dataQ <= rxBit;
        flagQ <= 1'b1;
      end
      if (regWrEn && cdrSel) begin
        divNrm <= regWrData[15:0];
        divOvd <= regWrData[31:16];
      end
    end
  end

  p_done_while_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    opDone |-> cycQ);
  p_flag_on_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    opDone |=> (flagQ && !cycQ));
  p_irq_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> !cycQ);
  p_busy_write_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cycQ && regWrEn && csrSel && !opDone) |=>
      (cycQ && $stable(selQ) && $stable(ovdQ) && $stable(ienQ) && $stable(pwrFieldQ)));
endmodule

// File: rtl/swm_top.sv
module swm_top
  import swm_pkg::*;
#(
  parameter int          NUM_PORTS   = 4,
  parameter int          ADDR_W      = 4,
  parameter logic [15:0] DIV_NRM_RST = 16'd175,
  parameter logic [15:0] DIV_OVD_RST = 16'd62
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  output logic [NUM_PORTS-1:0] busPullLow,
  input  logic [NUM_PORTS-1:0] busSense,
  output logic                 irqOut
);
  swmCmd_t cmd;
  logic    opDone, rxBit;

  swm_ctrl #(.ADDR_W(ADDR_W), .DIV_NRM_RST(DIV_NRM_RST), .DIV_OVD_RST(DIV_OVD_RST)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .opDone(opDone),
    .rxBit(rxBit), .cmd(cmd), .irqOut(irqOut));

  swm_timing #(.NUM_PORTS(NUM_PORTS)) u_timing (
    .clk(clk), .rstN(rstN), .cmd(cmd), .busSense(busSense),
    .busPullLow(busPullLow), .opDone(opDone), .rxBit(rxBit));
endmodule

// File: tb/sim_swm_top.sv
`timescale 1ns/1ps
module sim_swm_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [3:0]  pullLow;
  logic [3:0]  sense;
  logic        irqOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // device model: holds its port low inside a cycle window after a pull starts
  bit devOn = 0;
  int devPort = 0;
  int winLo = 0, winHi = 0;
  int winCnt = 100000;
  logic prevPull = 1'b0;

  always #5 clk = ~clk;

  swm_top u0 (.clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .busPullLow(pullLow),
    .busSense(sense), .irqOut(irqOut));

  always @(posedge clk) begin
    prevPull <= pullLow[devPort];
    if (pullLow[devPort] && !prevPull) winCnt <= 1;
    else if (winCnt < 100000) winCnt <= winCnt + 1;
  end

  always_comb
    for (int i = 0; i < 4; i++)
      sense[i] = !(pullLow[i] || (devOn && i == devPort && winCnt >= winLo && winCnt <= winHi));

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = '0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; #1; d = regRdData; regAddr = '0;
  endtask

  // start an operation and poll until it ends; optional write during the operation
  task automatic runOp(input logic [31:0] word, input int port, input bit midEn,
                       input logic [3:0] midAddr, input logic [31:0] midData,
                       output int lowCyc, output int otherCyc, output bit sawBusy,
                       output logic [31:0] csrAfter);
    int n = 0;
    lowCyc = 0; otherCyc = 0; sawBusy = 0;
    @(negedge clk);
    regAddr = 4'h0; regWrData = word; regWrEn = 1'b1;
    forever begin
      @(negedge clk);
      regWrEn = 1'b0; regAddr = 4'h0;
      if (n == 2 && midEn) begin regAddr = midAddr; regWrData = midData; regWrEn = 1'b1; end
      for (int i = 0; i < 4; i++)
        if (pullLow[i]) begin if (i == port) lowCyc++; else otherCyc++; end
      #1;
      if (!(n == 2 && midEn)) begin
        if (n == 0) sawBusy = regRdData[3];
        if (!regRdData[3] && n > 0) break;
      end
      n++;
      if (n > 20000) break;
    end
    regWrEn = 1'b0; regAddr = 4'h0;
    #1; csrAfter = regRdData;
  endtask

  task automatic tResetState();
    logic [31:0] d;
    regRead(4'h0, d); check("R1", "csr after reset", d, 32'h0);
    regRead(4'h4, d); check("R1", "divider after reset", d, 32'h003E00AF);
    check("R1", "irq after reset", {31'b0, irqOut}, 32'h0);
    check("R1", "lines after reset", {28'b0, pullLow}, 32'h0);
  endtask

  task automatic tDivider();
    logic [31:0] d;
    regWrite(4'h4, 32'h00010003);
    regRead(4'h4, d); check("R2", "divider readback", d, 32'h00010003);
  endtask

  task automatic tResetNormal();
    int lo, oth; bit b; logic [31:0] c;
    devOn = 1; devPort = 0; winLo = 1980; winHi = 2700;
    runOp(32'h0000_000A, 0, 0, 0, 0, lo, oth, b, c);
    check("R3", "cycle bit reads 1 while running", {31'b0, b}, 32'h1);
    check("R3", "cycle bit clears at end", {31'b0, c[3]}, 32'h0);
    check("R4", "reset low cycles", lo, 32'd1920);
    check("R4", "presence seen gives data 0", {31'b0, c[0]}, 32'h0);
    check("R10", "flag set at end", {31'b0, c[6]}, 32'h1);
    check("R10", "irq stays low when disabled", {31'b0, irqOut}, 32'h0);
    devOn = 0;
    runOp(32'h0000_000A, 0, 0, 0, 0, lo, oth, b, c);
    check("R4", "no presence gives data 1", {31'b0, c[0]}, 32'h1);
  endtask

  task automatic tSlots();
    int lo, oth; bit b; logic [31:0] c;
    devOn = 0;
    runOp(32'h0000_0008, 0, 0, 0, 0, lo, oth, b, c);
    check("R5", "write-0 low cycles", lo, 32'd240);
    check("R6", "write-0 samples own low", {31'b0, c[0]}, 32'h0);
    runOp(32'h0000_0009, 0, 0, 0, 0, lo, oth, b, c);
    check("R5", "write-1 low cycles", lo, 32'd24);
    check("R6", "read slot idle line gives 1", {31'b0, c[0]}, 32'h1);
    devOn = 1; devPort = 0; winLo = 1; winHi = 120;
    runOp(32'h0000_0009, 0, 0, 0, 0, lo, oth, b, c);
    check("R6", "read slot device low gives 0", {31'b0, c[0]}, 32'h0);
    devOn = 0;
  endtask

  task automatic tOverdrive();
    int lo, oth; bit b; logic [31:0] c;
    devOn = 1; devPort = 0; winLo = 100; winHi = 160;
    runOp(32'h0000_000E, 0, 0, 0, 0, lo, oth, b, c);
    check("R7", "overdrive reset low cycles", lo, 32'd96);
    check("R7", "overdrive presence data 0", {31'b0, c[0]}, 32'h0);
    devOn = 0;
    runOp(32'h0000_000C, 0, 0, 0, 0, lo, oth, b, c);
    check("R7", "overdrive write-0 low cycles", lo, 32'd12);
    runOp(32'h0000_000D, 0, 0, 0, 0, lo, oth, b, c);
    check("R7", "overdrive write-1 low cycles", lo, 32'd2);
    devOn = 1; winLo = 1; winHi = 10;
    runOp(32'h0000_000D, 0, 0, 0, 0, lo, oth, b, c);
    check("R7", "overdrive read device low gives 0", {31'b0, c[0]}, 32'h0);
    devOn = 0;
  endtask

  task automatic tPorts();
    int lo, oth; bit b; logic [31:0] c;
    devOn = 1; devPort = 2; winLo = 1980; winHi = 2700;
    runOp(32'h0000_020A, 2, 0, 0, 0, lo, oth, b, c);
    check("R8", "port 2 presence", {31'b0, c[0]}, 32'h0);
    check("R8", "port 2 pulled", lo, 32'd1920);
    check("R8", "other ports untouched", oth, 32'd0);
    runOp(32'h0000_000A, 0, 0, 0, 0, lo, oth, b, c);
    check("R8", "device on other port not seen", {31'b0, c[0]}, 32'h1);
    runOp(32'h0000_0908, 0, 0, 0, 0, lo, oth, b, c);
    check("R8", "out-of-range port drives nothing", lo + oth, 32'd0);
    check("R8", "out-of-range port samples 1", {31'b0, c[0]}, 32'h1);
    devOn = 0;
  endtask

  task automatic tBusyWrite();
    int lo, oth; bit b; logic [31:0] c;
    runOp(32'h0000_0009, 0, 1, 4'h0, 32'hFFFF_0388, lo, oth, b, c);
    check("R9", "busy write left port/enable/power unchanged", c & 32'hFFFF_0F90, 32'h0);
    check("R9", "busy write did not change slot", lo, 32'd24);
    check("R9", "busy write no other line", oth, 32'd0);
    check("R9", "irq still disabled", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic tDividerLatch();
    int lo, oth; bit b; logic [31:0] c; logic [31:0] d;
    runOp(32'h0000_0009, 0, 1, 4'h4, 32'h0001_0007, lo, oth, b, c);
    check("R11", "mid-op divider change ignored", lo, 32'd24);
    runOp(32'h0000_0009, 0, 0, 0, 0, lo, oth, b, c);
    check("R11", "new divider used next op", lo, 32'd48);
    regWrite(4'h4, 32'h00010003);
    regRead(4'h4, d); check("R2", "divider restored", d, 32'h00010003);
  endtask

  task automatic tIrq();
    int lo, oth; bit b; logic [31:0] c;
    runOp(32'h0000_0089, 0, 0, 0, 0, lo, oth, b, c);
    check("R10", "irq asserted when enabled", {31'b0, irqOut}, 32'h1);
    check("R10", "flag and enable read back", c & 32'hC0, 32'hC0);
    regWrite(4'h0, 32'h0000_0080);
    check("R10", "irq cleared by write", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic tPower();
    logic [31:0] d; int lowSeen = 0;
    regWrite(4'h0, 32'hBEEF_0010);
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (|pullLow) lowSeen++; end
    regRead(4'h0, d);
    check("R12", "power bits readback", d, 32'hBEEF_0010);
    check("R12", "power bits drive no line", lowSeen, 32'd0);
  endtask

  initial begin
    #200000000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    tResetState();
    tDivider();
    tResetNormal();
    tSlots();
    tOverdrive();
    tPorts();
    tBusyWrite();
    tDividerLatch();
    tIrq();
    tPower();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule